// File: doc/BRIEF.md
# Paged Stack Pointer with Context Sequencer

This block holds the stack pointer of an 8-bit core and produces the address of every stack access. The pointer is 16 bits wide, but its upper byte is fixed in hardware, so all stack traffic stays inside one 256-byte page (0100h to 01FFh by default). The pointer always names the next free byte: a push writes at the pointer and then moves it down, while a pop first moves the pointer up and then reads there. Moving past either end of the page silently wraps to the other end, and the old bytes there are overwritten with no indication.

Besides single pushes and pops, the block runs multi-byte context transfers on its own. A subroutine context takes two bytes, an interrupt context takes five. On a save the low program-counter byte goes to the first address and the rest follow; a restore reads the same registers back in exactly the opposite order. During a transfer the block reports which register each access carries, so the surrounding core can steer its data path. A reset-stack command and a direct load of the low pointer byte complete the control set.

Top module: `sp_unit`

## Requirements
- R1: The upper byte of `sp_o` and of `addr_o` always equals the fixed page (01h by default); only the low byte moves.
- R2: After reset, and in the cycle after `rsp_i` is high, `sp_o` is 01FFh; `rsp_i` wins over every other input, suppresses any access in its cycle and ends a running context transfer.
- R3: A push (`push_i`) gives `acc_valid_o`=1, `acc_write_o`=1 and `addr_o`=`sp_o` in the same cycle; in the next cycle `sp_o` is one lower.
- R4: A pop (`pop_i`) gives `acc_valid_o`=1, `acc_write_o`=0 and `addr_o`=`sp_o`+1 in the same cycle; in the next cycle `sp_o` equals that address.
- R5: A push at 0100h addresses 0100h and leaves `sp_o` at 01FFh; a pop at 01FFh addresses 0100h and leaves `sp_o` at 0100h; no flag is raised.
- R6: `ld_i` loads `ld_data_i` into the low pointer byte for the next cycle; a push or pop in the same cycle is dropped (`acc_valid_o`=0).
- R7: `ctx_start_i` starts a transfer of 2 bytes (`ctx_irq_i`=0) or 5 bytes (`ctx_irq_i`=1); `ctx_busy_o` is high for exactly that many cycles starting the cycle after the start, with one access per cycle and `ctx_idx_o` counting 0 upward.
- R8: A save (`ctx_restore_i`=0) writes at descending addresses in the order PCL, PCH, X, A, CC (a subroutine save: PCL, PCH); `ctx_reg_o` codes are PCL=0, PCH=1, X=2, A=3, CC=4.
- R9: A restore (`ctx_restore_i`=1) reads at ascending addresses in the order CC, A, X, PCH, PCL (a subroutine restore: PCH, PCL).
- R10: While `ctx_busy_o` is high, `push_i`, `pop_i`, `ld_i` and `ctx_start_i` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Single-byte push request |
| pop_i | input | 1 | Single-byte pop request |
| rsp_i | input | 1 | Return the pointer to the top of the page |
| ld_i | input | 1 | Load the low pointer byte |
| ld_data_i | input | 8 | Value for the low pointer byte |
| ctx_start_i | input | 1 | Start a context transfer |
| ctx_irq_i | input | 1 | Transfer size: 0 subroutine (2 bytes), 1 interrupt (5 bytes) |
| ctx_restore_i | input | 1 | Transfer direction: 0 save, 1 restore |
| acc_valid_o | output | 1 | A stack access happens this cycle |
| acc_write_o | output | 1 | The access is a write (push) |
| addr_o | output | 16 | Address of the access |
| sp_o | output | 16 | Current stack pointer |
| ctx_busy_o | output | 1 | Context transfer in progress |
| ctx_idx_o | output | 3 | Position within the transfer |
| ctx_reg_o | output | 3 | Register carried by the current transfer access |

## Verification
The checker takes for granted that push and pop are never requested in the same cycle; it flags that case as an illegal input rather than treating it as behaviour. The stimulus issues at most one of the two per cycle, always through one driver task per operation, so the flag never fires. Loads, resets and context starts are freely mixed with pushes, and requests made while a transfer runs are sent on purpose to show they have no effect on the accesses or the final pointer.

// File: rtl/sp_pkg.sv
package sp_pkg;

   // register carried by each context transfer slot
   typedef enum logic [2:0] {
      CTX_PCL = 3'd0,
      CTX_PCH = 3'd1,
      CTX_X   = 3'd2,
      CTX_A   = 3'd3,
      CTX_CC  = 3'd4
   } ctx_reg_e;

   localparam int CALL_BYTES = 2;
   localparam int IRQ_BYTES  = 5;
   localparam int CTX_IDX_W  = $clog2(IRQ_BYTES);

endpackage

// File: rtl/sp_ptr_reg.sv
module sp_ptr_reg #(
   parameter int LOW_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rsp,
   input  logic             ld,
   input  logic [LOW_W-1:0] ld_val,
   input  logic             step_en,
   input  logic             step_dn,
   output logic [LOW_W-1:0] low_q
);

   localparam logic [LOW_W-1:0] TOP_LOW = '1;
   localparam logic [LOW_W-1:0] ONE     = LOW_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n || rsp) begin
         low_q <= TOP_LOW;
      end else if (ld) begin
         low_q <= ld_val;
      end else if (step_en) begin
         // modulo arithmetic gives the silent wrap inside the page
         low_q <= step_dn ? (low_q - ONE) : (low_q + ONE);
      end
   end

endmodule

// File: rtl/sp_ctx_seq.sv
module sp_ctx_seq
   import sp_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 abort,
   input  logic                 start,
   input  logic                 irq,
   input  logic                 restore,
   output logic                 busy,
   output logic                 dir_rd,
   output logic [CTX_IDX_W-1:0] idx,
   output ctx_reg_e             reg_code
);

   localparam logic [CTX_IDX_W-1:0] LAST_CALL = CTX_IDX_W'(CALL_BYTES - 1);
   localparam logic [CTX_IDX_W-1:0] LAST_IRQ  = CTX_IDX_W'(IRQ_BYTES - 1);

   logic                 busy_q;
   logic                 irq_q;
   logic                 rd_q;
   logic [CTX_IDX_W-1:0] step_q;
   logic [CTX_IDX_W-1:0] last_idx;

   assign last_idx = irq_q ? LAST_IRQ : LAST_CALL;

   always_ff @(posedge clk) begin
      if (!rst_n || abort) begin
         busy_q <= 1'b0;
         step_q <= '0;
         irq_q  <= 1'b0;
         rd_q   <= 1'b0;
      end else if (busy_q) begin
         if (step_q == last_idx) begin
            busy_q <= 1'b0;
            step_q <= '0;
         end else begin
            step_q <= step_q + CTX_IDX_W'(1);
         end
      end else if (start) begin
         busy_q <= 1'b1;
         step_q <= '0;
         irq_q  <= irq;
         rd_q   <= restore;
      end
   end

   // save runs the slots upward from PCL, restore runs them back down
   always_comb begin
      if (!busy_q)   reg_code = CTX_PCL;
      else if (rd_q) reg_code = ctx_reg_e'(3'(last_idx - step_q));
      else           reg_code = ctx_reg_e'(3'(step_q));
   end

   assign busy   = busy_q;
   assign dir_rd = rd_q;
   assign idx    = step_q;

endmodule

// File: rtl/sp_addr_gen.sv
module sp_addr_gen #(
   parameter int ADDR_W = 16,
   parameter int LOW_W  = 8,
   parameter int PAGE   = 1
) (
   input  logic [LOW_W-1:0]  low,
   input  logic              wr,
   output logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] sp
);

   localparam int HIGH_W = ADDR_W - LOW_W;
   localparam logic [HIGH_W-1:0] PAGE_V = HIGH_W'(PAGE);

   logic [LOW_W-1:0] acc_low;

   // write goes to the free slot, read goes one above it
   assign acc_low = wr ? low : (low + LOW_W'(1));

   generate
      if (HIGH_W > 0) begin : g_paged
         assign addr = {PAGE_V, acc_low};
         assign sp   = {PAGE_V, low};
      end else begin : g_flat
         assign addr = acc_low;
         assign sp   = low;
      end
   endgenerate

endmodule

// File: rtl/sp_unit.sv
module sp_unit
   import sp_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int LOW_W  = 8,
   parameter int PAGE   = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 push_i,
   input  logic                 pop_i,
   input  logic                 rsp_i,
   input  logic                 ld_i,
   input  logic [LOW_W-1:0]     ld_data_i,
   input  logic                 ctx_start_i,
   input  logic                 ctx_irq_i,
   input  logic                 ctx_restore_i,
   output logic                 acc_valid_o,
   output logic                 acc_write_o,
   output logic [ADDR_W-1:0]    addr_o,
   output logic [ADDR_W-1:0]    sp_o,
   output logic                 ctx_busy_o,
   output logic [CTX_IDX_W-1:0] ctx_idx_o,
   output logic [2:0]           ctx_reg_o
);

   localparam int HIGH_W = ADDR_W - LOW_W;

   generate
      if (LOW_W < 2 || HIGH_W < 1) begin : g_bad_width
         $error("sp_unit: LOW_W must be at least 2 and below ADDR_W");
      end
      if (PAGE < 0 || PAGE >= (1 << HIGH_W)) begin : g_bad_page
         $error("sp_unit: PAGE does not fit in the upper address field");
      end
   endgenerate

   logic             seq_busy;
   logic             seq_rd;
   ctx_reg_e         seq_reg;
   logic             ext_ok;
   logic             ext_push;
   logic             ext_pop;
   logic             seq_acc;
   logic             ld_eff;
   logic             acc_valid;
   logic             acc_write;
   logic [LOW_W-1:0] low_q;

   // rsp beats load, load beats single accesses, a transfer locks them out
   assign ext_ok    = !seq_busy && !rsp_i && !ld_i;
   assign ext_push  = push_i && ext_ok;
   assign ext_pop   = pop_i && !push_i && ext_ok;
   assign seq_acc   = seq_busy && !rsp_i;
   assign ld_eff    = ld_i && !seq_busy && !rsp_i;
   assign acc_valid = ext_push || ext_pop || seq_acc;
   assign acc_write = ext_push || (seq_acc && !seq_rd);

   sp_ptr_reg #(
      .LOW_W (LOW_W)
   ) i_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .rsp     (rsp_i),
      .ld      (ld_eff),
      .ld_val  (ld_data_i),
      .step_en (acc_valid),
      .step_dn (acc_write),
      .low_q   (low_q)
   );

   sp_ctx_seq i_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .abort    (rsp_i),
      .start    (ctx_start_i),
      .irq      (ctx_irq_i),
      .restore  (ctx_restore_i),
      .busy     (seq_busy),
      .dir_rd   (seq_rd),
      .idx      (ctx_idx_o),
      .reg_code (seq_reg)
   );

   sp_addr_gen #(
      .ADDR_W (ADDR_W),
      .LOW_W  (LOW_W),
      .PAGE   (PAGE)
   ) i_addr (
      .low  (low_q),
      .wr   (acc_write),
      .addr (addr_o),
      .sp   (sp_o)
   );

   assign acc_valid_o = acc_valid;
   assign acc_write_o = acc_write;
   assign ctx_busy_o  = seq_busy;
   assign ctx_reg_o   = seq_reg;

endmodule

// File: rtl/sp_unit_chk.sv
module sp_unit_chk
   import sp_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int LOW_W  = 8,
   parameter int PAGE   = 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 push_i,
   input logic                 pop_i,
   input logic                 rsp_i,
   input logic                 ld_i,
   input logic [LOW_W-1:0]     ld_data_i,
   input logic                 acc_valid_o,
   input logic                 acc_write_o,
   input logic [ADDR_W-1:0]    addr_o,
   input logic [ADDR_W-1:0]    sp_o,
   input logic                 ctx_busy_o,
   input logic [CTX_IDX_W-1:0] ctx_idx_o,
   input logic [2:0]           ctx_reg_o
);

   localparam int HIGH_W = ADDR_W - LOW_W;
   localparam logic [ADDR_W-1:0] TOP_SP = {HIGH_W'(PAGE), {LOW_W{1'b1}}};

   // input assumption behind R3 and R4: one direction per cycle
   AST_NO_DUAL_REQ: assert property (@(posedge clk) disable iff (!rst_n) !(push_i && pop_i)); // R3
   AST_RSP_TOP: assert property (@(posedge clk) disable iff (!rst_n) rsp_i |=> (sp_o == TOP_SP) && !ctx_busy_o); // R2
   AST_PUSH_DOWN: assert property (@(posedge clk) disable iff (!rst_n) (acc_valid_o && acc_write_o) |=> sp_o[LOW_W-1:0] == LOW_W'($past(addr_o[LOW_W-1:0]) - LOW_W'(1))); // R3
   AST_POP_UP: assert property (@(posedge clk) disable iff (!rst_n) (acc_valid_o && !acc_write_o) |=> sp_o == $past(addr_o)); // R4
   AST_LD_DROPS: assert property (@(posedge clk) disable iff (!rst_n) (ld_i && !ctx_busy_o) |-> !acc_valid_o); // R6
   AST_LD_LOADS: assert property (@(posedge clk) disable iff (!rst_n) (ld_i && !ctx_busy_o && !rsp_i) |=> sp_o[LOW_W-1:0] == $past(ld_data_i)); // R6
   AST_BUSY_ACCESS: assert property (@(posedge clk) disable iff (!rst_n) (ctx_busy_o && !rsp_i) |-> acc_valid_o); // R7
   AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n) ctx_busy_o |-> (int'(ctx_idx_o) < IRQ_BYTES)); // R7
   AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n) (ctx_busy_o && ctx_idx_o != '0) |-> ctx_idx_o == CTX_IDX_W'($past(ctx_idx_o) + CTX_IDX_W'(1))); // R7
   AST_SAVE_FIRST: assert property (@(posedge clk) disable iff (!rst_n) (ctx_busy_o && acc_write_o && ctx_idx_o == '0) |-> ctx_reg_o == 3'(CTX_PCL)); // R8
   AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n) (ctx_busy_o && !rsp_i && $past(ctx_busy_o)) |-> acc_write_o == $past(acc_write_o)); // R10

endmodule

bind sp_unit sp_unit_chk #(
   .ADDR_W (ADDR_W),
   .LOW_W  (LOW_W),
   .PAGE   (PAGE)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .push_i      (push_i),
   .pop_i       (pop_i),
   .rsp_i       (rsp_i),
   .ld_i        (ld_i),
   .ld_data_i   (ld_data_i),
   .acc_valid_o (acc_valid_o),
   .acc_write_o (acc_write_o),
   .addr_o      (addr_o),
   .sp_o        (sp_o),
   .ctx_busy_o  (ctx_busy_o),
   .ctx_idx_o   (ctx_idx_o),
   .ctx_reg_o   (ctx_reg_o)
);

// File: tb/test_sp_unit.sv
module test_sp_unit;

   localparam time TCK = 10ns;

   typedef struct {
      logic [15:0] addr;
      logic        wr;
      logic        ctx;
      logic [2:0]  rg;
      logic [2:0]  idx;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        push_i = 1'b0, pop_i = 1'b0, rsp_i = 1'b0, ld_i = 1'b0;
   logic [7:0]  ld_data_i = 8'h00;
   logic        ctx_start_i = 1'b0, ctx_irq_i = 1'b0, ctx_restore_i = 1'b0;
   logic        acc_valid_o, acc_write_o, ctx_busy_o;
   logic [15:0] addr_o, sp_o;
   logic [2:0]  ctx_idx_o, ctx_reg_o;

   int   total = 0;
   int   bad = 0;
   exp_t exp_q[$];
   logic [7:0] m_sp;

   always #(TCK/2) clk = ~clk;

   sp_unit i_sp_unit (
      .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .rsp_i(rsp_i),
      .ld_i(ld_i), .ld_data_i(ld_data_i), .ctx_start_i(ctx_start_i),
      .ctx_irq_i(ctx_irq_i), .ctx_restore_i(ctx_restore_i),
      .acc_valid_o(acc_valid_o), .acc_write_o(acc_write_o), .addr_o(addr_o),
      .sp_o(sp_o), .ctx_busy_o(ctx_busy_o), .ctx_idx_o(ctx_idx_o), .ctx_reg_o(ctx_reg_o)
   );

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   // monitor: every access the design makes is compared with the scoreboard
   always @(negedge clk) begin
      if (rst_n && acc_valid_o) begin
         total++;
         if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL R6/R10 unexpected access got=%h exp=none", addr_o);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            if (addr_o !== e.addr || acc_write_o !== e.wr ||
                (e.ctx && (ctx_reg_o !== e.rg || ctx_idx_o !== e.idx))) begin
               bad++;
               $display("FAIL %s got=%h/%b/%0d/%0d exp=%h/%b/%0d/%0d", e.tag,
                        addr_o, acc_write_o, ctx_reg_o, ctx_idx_o,
                        e.addr, e.wr, e.rg, e.idx);
            end
         end
      end
   end

   // one cycle of stimulus, applied just after a rising edge
   task automatic drive(input logic p, input logic q, input logic r, input logic l,
                        input logic [7:0] d, input logic s, input logic irq, input logic rest);
      push_i = p; pop_i = q; rsp_i = r; ld_i = l; ld_data_i = d;
      ctx_start_i = s; ctx_irq_i = irq; ctx_restore_i = rest;
      @(posedge clk);
      #1;
      push_i = 0; pop_i = 0; rsp_i = 0; ld_i = 0; ld_data_i = 0;
      ctx_start_i = 0; ctx_irq_i = 0; ctx_restore_i = 0;
   endtask

   task automatic expect_acc(input logic [7:0] lo, input logic wr, input logic ctx,
                             input logic [2:0] rg, input logic [2:0] idx, input string tag);
      exp_t e;
      e.addr = {8'h01, lo}; e.wr = wr; e.ctx = ctx; e.rg = rg; e.idx = idx; e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic do_push(input string tag);
      expect_acc(m_sp, 1'b1, 1'b0, 3'd0, 3'd0, tag);
      m_sp = m_sp - 8'd1;
      drive(1, 0, 0, 0, 8'h00, 0, 0, 0);
   endtask

   task automatic do_pop(input string tag);
      m_sp = m_sp + 8'd1;
      expect_acc(m_sp, 1'b0, 1'b0, 3'd0, 3'd0, tag);
      drive(0, 1, 0, 0, 8'h00, 0, 0, 0);
   endtask

   // full context transfer; noise sends requests that must be ignored (R10)
   task automatic do_ctx(input logic irq, input logic rest, input logic noise, input string tag);
      int n;
      n = irq ? 5 : 2;
      for (int i = 0; i < n; i++) begin
         logic [2:0] rg;
         rg = rest ? 3'(n - 1 - i) : 3'(i);
         if (!rest) begin
            expect_acc(m_sp, 1'b1, 1'b1, rg, 3'(i), tag);
            m_sp = m_sp - 8'd1;
         end else begin
            m_sp = m_sp + 8'd1;
            expect_acc(m_sp, 1'b0, 1'b1, rg, 3'(i), tag);
         end
      end
      drive(0, 0, 0, 0, 8'h00, 1, irq, rest);
      chk("R7 busy after start", {15'd0, ctx_busy_o}, 16'd1);
      for (int i = 0; i < n; i++) begin
         if (noise) drive(1, 0, 0, i[0], 8'h55, 1, ~irq, ~rest);
         else       drive(0, 0, 0, 0, 8'h00, 0, 0, 0);
      end
      chk("R7 busy length", {15'd0, ctx_busy_o}, 16'd0);
      chk({tag, " final pointer"}, sp_o, {8'h01, m_sp});
   endtask

   initial begin
      #(TCK * 20000);
      bad++;
      total++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      m_sp = 8'hFF;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;

      // R2 reset state, R1 page byte
      chk("R2 reset pointer", sp_o, 16'h01FF);
      chk("R7 idle after reset", {15'd0, ctx_busy_o}, 16'd0);
      chk("R1 access idle", {15'd0, acc_valid_o}, 16'd0);

      // R3 pushes
      do_push("R3 push");
      do_push("R3 push");
      do_push("R3 push");
      chk("R3 pointer after pushes", sp_o, 16'h01FC);
      chk("R1 page byte", {8'h00, sp_o[15:8]}, 16'h0001);

      // R4 pops
      do_pop("R4 pop");
      do_pop("R4 pop");
      chk("R4 pointer after pops", sp_o, 16'h01FE);

      // R6 load with a push in the same cycle: push dropped
      drive(1, 0, 0, 1, 8'h00, 0, 0, 0);
      m_sp = 8'h00;
      chk("R6 load value", sp_o, 16'h0100);

      // R5 wrap both ways
      do_push("R5 push wrap");
      chk("R5 pointer after push wrap", sp_o, 16'h01FF);
      do_pop("R5 pop wrap");
      chk("R5 pointer after pop wrap", sp_o, 16'h0100);

      // R2 rsp with a pop: pop dropped, pointer to top
      drive(0, 1, 1, 0, 8'h00, 0, 0, 0);
      m_sp = 8'hFF;
      chk("R2 rsp pointer", sp_o, 16'h01FF);

      // R8 interrupt save, R9 restore with ignored requests (R10)
      do_ctx(1'b1, 1'b0, 1'b0, "R8 irq save");
      chk("R8 pointer after irq save", sp_o, 16'h01FA);
      do_ctx(1'b1, 1'b1, 1'b1, "R9 R10 irq restore");
      chk("R10 pointer after noisy restore", sp_o, 16'h01FF);

      // subroutine save across the page bottom, then restore across it
      drive(0, 0, 0, 1, 8'h01, 0, 0, 0);
      m_sp = 8'h01;
      do_ctx(1'b0, 1'b0, 1'b0, "R8 R5 call save");
      chk("R5 pointer after call save wrap", sp_o, 16'h01FF);
      do_ctx(1'b0, 1'b1, 1'b0, "R9 R5 call restore");
      chk("R9 pointer after call restore", sp_o, 16'h0101);

      // R2 abort: two slots of an interrupt save, then rsp
      expect_acc(m_sp, 1'b1, 1'b1, 3'd0, 3'd0, "R2 abort slot");
      expect_acc(m_sp - 8'd1, 1'b1, 1'b1, 3'd1, 3'd1, "R2 abort slot");
      drive(0, 0, 0, 0, 8'h00, 1, 1, 0);
      drive(0, 0, 0, 0, 8'h00, 0, 0, 0);
      drive(0, 0, 0, 0, 8'h00, 0, 0, 0);
      drive(0, 0, 1, 0, 8'h00, 0, 0, 0);
      m_sp = 8'hFF;
      chk("R2 abort ends transfer", {15'd0, ctx_busy_o}, 16'd0);
      chk("R2 abort pointer", sp_o, 16'h01FF);
      drive(0, 0, 0, 0, 8'h00, 0, 0, 0);

      chk("R7 all expected accesses seen", 16'(exp_q.size()), 16'd0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule